// File: doc/BRIEF.md
# System Configuration Registers with Interrupt-Line Source Selection

This block is a small bank of configuration words on a simple 32-bit register bus: a word address, a write strobe, write data and combinational read data. Each word has its own per-bit rules. Some bits are plain read/write. Some are unimplemented and always read zero. Some can only be set and stay at 1 until reset. One bit can only be cleared. One status bit is cleared by writing 1 and cannot be set by software.

The block also steers GPIO pin levels onto sixteen external-interrupt lines. Four of its words hold one 4-bit port code per line. Line n copies the level of pin n on the port that its code selects. The GPIO inputs arrive as one flat vector, sixteen pins per port. The block adds no latency on the line path: the line outputs are combinational in the GPIO inputs and the stored port codes.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset, every word reads zero except the main control word at byte offset 0x04, which reads 0x7C000001. The word map by byte offset is: 0x00 remap, 0x04 control-1, 0x08/0x0C/0x10/0x14 line-select 0 to 3, 0x18 SRAM status, 0x1C control-2, 0x20 protect-low, 0x24 key, 0x28 protect-high. The bus carries the offset divided by four.
- R2: Unimplemented bits read zero and ignore writes. The kept masks are: remap 0x00000107, control-1 0xFCFF0101, each line-select 0x0000FFFF, key 0x000000FF. The SRAM status word and control-2 bits outside 3:0 read zero.
- R3: Kept bits of remap, control-1 (except bit 0), the line-select words and key can be written to 1 and back to 0.
- R4: Control-1 bit 0 is clear-only. After a write of 0, later writes of 1 leave it at 0 until reset.
- R5: Control-2 bits 3:0 are set-only. A write of 1 sets a bit, and a later write of 0 does not clear it.
- R6: Every bit of protect-low and protect-high is set-only and stays at 1 until reset.
- R7: Control-2 bit 8 is a write-1-to-clear status flag. A software write of 1 never sets it, so it reads 0 afterwards.
- R8: Line-select word k holds the codes for lines 4k to 4k+3. The code for line 4k+j sits in bits 4j+3:4j.
- R9: Code p selects port p. GPIO input index p*16+pin is pin `pin` of port p. Code 0 is the reset value, so after reset port 0 pin n drives line n.
- R10: Line n follows pin n of the selected port only. Pin n of any other port, and any other pin number, has no effect on line n.
- R11: A code at or above the number of implemented ports drives its line low.
- R12: Byte offsets 0x2C and above read zero, and writes to them change no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wordaddr | input | WORD_AW | Word address (byte offset divided by four) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| gpio_in | input | NUM_PORTS*16 | GPIO pin levels, index port*16+pin |
| line_out | output | 16 | External-interrupt line levels |

## Verification
The bench builds the block with NUM_PORTS set to 3 instead of the default 8. With three ports, codes 3 and 15 select ports that do not exist, so the path that drives an unselected line low is exercised. A third real port also lets the bench show that a non-zero code in the highest nibble of a select word reaches line 15. WORD_AW stays at 6, so the bus can reach both the first invalid offset, 0x2C, and the last one, 0xFC.

// File: rtl/syscfg_pkg.sv
// Shared constants for the system configuration block: word indexes,
// per-word kept-bit masks and reset values. Assumes 32-bit words and
// sixteen pins per GPIO port.
package syscfg_pkg;
    localparam int REG_COUNT  = 11;
    localparam int PORT_PINS  = 16;
    localparam int LINE_COUNT = 16;
    localparam int CODE_W     = 4;
    localparam int SEL_REGS   = LINE_COUNT * CODE_W / 32 * 2;

    localparam int IDX_REMAP  = 0;
    localparam int IDX_CTRL1  = 1;
    localparam int IDX_SEL0   = 2;
    localparam int IDX_SRAMST = 6;
    localparam int IDX_CTRL2  = 7;
    localparam int IDX_WPLO   = 8;
    localparam int IDX_KEY    = 9;
    localparam int IDX_WPHI   = 10;

    localparam logic [31:0] REMAP_KEEP = 32'h0000_0107;
    localparam logic [31:0] CTRL1_KEEP = 32'hFCFF_0101;
    localparam logic [31:0] CTRL1_INIT = 32'h7C00_0001;
    localparam logic [31:0] CTRL1_LOCK = 32'h0000_0001;
endpackage

// File: rtl/cfg_regfile.sv
// Register file of the configuration block. Holds every stored word and
// applies each bit's access rule on a bus write. Assumes one write per
// cycle on bus_wr, and a read path that is purely combinational on
// bus_wordaddr. Exposes the sixteen line codes as one flat vector.
module cfg_regfile
    import syscfg_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WORD_AW-1:0]           bus_wordaddr,
    input  logic                         bus_wr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [LINE_COUNT*CODE_W-1:0] sel_flat
);
    localparam int SEL_W = LINE_COUNT * CODE_W / 4;

    logic [REG_COUNT-1:0] wr_hit;
    logic [31:0]          remap_q;
    logic [31:0]          ctrl1_q;
    logic [3:0]           ctrl2_q;
    logic [31:0]          wp_lo_q;
    logic [31:0]          wp_hi_q;
    logic [7:0]           key_q;
    logic                 addr_ok;

    // one-hot write decode per word
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_hit
        assign wr_hit[i] = bus_wr && (bus_wordaddr == WORD_AW'(i));
    end

    assign addr_ok = bus_wordaddr < WORD_AW'(REG_COUNT);

    // line-select words: plain read/write, low half kept
    for (genvar g = 0; g < 4; g++) begin : g_sel
        logic [SEL_W-1:0] sel_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                     sel_q <= '0;
            else if (wr_hit[IDX_SEL0 + g])  sel_q <= bus_wdata[SEL_W-1:0];
        end
        assign sel_flat[g*SEL_W +: SEL_W] = sel_q;
    end

    // remap word: masked read/write
    always_ff @(posedge clk) begin
        if (!rst_n)                 remap_q <= '0;
        else if (wr_hit[IDX_REMAP]) remap_q <= bus_wdata & REMAP_KEEP;
    end

    // control-1: masked read/write with a clear-only lock bit
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl1_q <= CTRL1_INIT;
        else if (wr_hit[IDX_CTRL1]) ctrl1_q <= (bus_wdata & CTRL1_KEEP & ~CTRL1_LOCK)
                                             | (ctrl1_q & bus_wdata & CTRL1_LOCK);
    end

    // control-2: set-only low nibble
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl2_q <= '0;
        else if (wr_hit[IDX_CTRL2]) ctrl2_q <= ctrl2_q | bus_wdata[3:0];
    end

    // protect words: every bit set-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_lo_q <= '0;
            wp_hi_q <= '0;
        end else begin
            if (wr_hit[IDX_WPLO]) wp_lo_q <= wp_lo_q | bus_wdata;
            if (wr_hit[IDX_WPHI]) wp_hi_q <= wp_hi_q | bus_wdata;
        end
    end

    // key word: low byte read/write
    always_ff @(posedge clk) begin
        if (!rst_n)               key_q <= '0;
        else if (wr_hit[IDX_KEY]) key_q <= bus_wdata[7:0];
    end

    // read multiplexer; status word, flag bit and invalid offsets read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_wordaddr)
            WORD_AW'(IDX_REMAP):    bus_rdata = remap_q;
            WORD_AW'(IDX_CTRL1):    bus_rdata = ctrl1_q;
            WORD_AW'(IDX_SEL0):     bus_rdata = {16'b0, sel_flat[15:0]};
            WORD_AW'(IDX_SEL0 + 1): bus_rdata = {16'b0, sel_flat[31:16]};
            WORD_AW'(IDX_SEL0 + 2): bus_rdata = {16'b0, sel_flat[47:32]};
            WORD_AW'(IDX_SEL0 + 3): bus_rdata = {16'b0, sel_flat[63:48]};
            WORD_AW'(IDX_SRAMST):   bus_rdata = '0;
            WORD_AW'(IDX_CTRL2):    bus_rdata = {28'b0, ctrl2_q};
            WORD_AW'(IDX_WPLO):     bus_rdata = wp_lo_q;
            WORD_AW'(IDX_KEY):      bus_rdata = {24'b0, key_q};
            WORD_AW'(IDX_WPHI):     bus_rdata = wp_hi_q;
            default:                bus_rdata = '0;
        endcase
    end

    // R4
    lock_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$rose(ctrl1_q[0]));

    // R5
    ctrl2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ctrl2_q & $past(ctrl2_q)) == $past(ctrl2_q)));

    // R6
    protect_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((wp_lo_q & $past(wp_lo_q)) == $past(wp_lo_q))
                       && ((wp_hi_q & $past(wp_hi_q)) == $past(wp_hi_q))));

    // R12
    invalid_wr_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !addr_ok) |=>
            $stable({remap_q, ctrl1_q, sel_flat, ctrl2_q, wp_lo_q, wp_hi_q, key_q}));
endmodule

// File: rtl/line_mux.sv
// Per-line source selector. For each of the sixteen interrupt lines it
// gathers pin n of every port into a sixteen-entry column (absent ports
// tied low) and picks the entry named by that line's 4-bit code.
// Assumes NUM_PORTS is between 1 and 16.
module line_mux
    import syscfg_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic [NUM_PORTS*PORT_PINS-1:0] gpio_in,
    input  logic [LINE_COUNT*CODE_W-1:0]   sel_flat,
    output logic [LINE_COUNT-1:0]          line_out
);
    localparam int COL_W = 1 << CODE_W;

    for (genvar n = 0; n < LINE_COUNT; n++) begin : g_line
        logic [COL_W-1:0]  pin_col;
        logic [CODE_W-1:0] code;

        // column of pin n across every possible port code
        for (genvar p = 0; p < COL_W; p++) begin : g_col
            if (p < NUM_PORTS) begin : g_real
                assign pin_col[p] = gpio_in[p*PORT_PINS + n];
            end else begin : g_absent
                assign pin_col[p] = 1'b0;
            end
        end

        assign code = sel_flat[n*CODE_W +: CODE_W];

        // pick the selected port's pin for this line
        always_comb line_out[n] = pin_col[code];
    end
endmodule

// File: rtl/sys_cfg_regs.sv
// Top of the system configuration block: register file on the bus side,
// line selector on the GPIO side. Assumes a synchronous active-low reset
// and GPIO inputs already synchronous to clk.
module sys_cfg_regs
    import syscfg_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int WORD_AW   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [WORD_AW-1:0]             bus_wordaddr,
    input  logic                           bus_wr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_PORTS*PORT_PINS-1:0] gpio_in,
    output logic [LINE_COUNT-1:0]          line_out
);
    logic [LINE_COUNT*CODE_W-1:0] sel_flat;

    cfg_regfile #(.WORD_AW(WORD_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wordaddr (bus_wordaddr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .sel_flat     (sel_flat)
    );

    line_mux #(.NUM_PORTS(NUM_PORTS)) u_mux (
        .gpio_in  (gpio_in),
        .sel_flat (sel_flat),
        .line_out (line_out)
    );

    for (genvar n = 0; n < LINE_COUNT; n++) begin : g_chk
        logic any_pin;

        // is pin n high on any implemented port
        always_comb begin
            any_pin = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) any_pin = any_pin | gpio_in[p*PORT_PINS + n];
        end

        // R10
        own_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_out[n] |-> any_pin);

        // R11
        dead_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel_flat[n*CODE_W +: CODE_W]) >= NUM_PORTS) |-> !line_out[n]);
    end
endmodule

// File: tb/sys_cfg_regs_tb.sv
`timescale 1ns/1ps
module sys_cfg_regs_tb;
    localparam int PORTS = 3;
    localparam int AW    = 6;
    localparam int GW    = PORTS * 16;
    localparam int NVEC  = 30;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] wa;
    logic          wr;
    logic [31:0]   wd;
    logic [31:0]   rd;
    logic [GW-1:0] gpio;
    logic [15:0]   lines;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #2 clk = ~clk;

    sys_cfg_regs #(.NUM_PORTS(PORTS), .WORD_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wordaddr(wa), .bus_wr(wr),
        .bus_wdata(wd), .bus_rdata(rd), .gpio_in(gpio), .line_out(lines)
    );

    // {requirement number, byte offset, write data, expected read-back}
    localparam logic [75:0] VEC [NVEC] = '{
        {4'd2,  8'h00, 32'hFFFF_FFFF, 32'h0000_0107},  // R2
        {4'd3,  8'h00, 32'h0000_0000, 32'h0000_0000},  // R3
        {4'd2,  8'h04, 32'h7F00_FEFF, 32'h7C00_0001},  // R2
        {4'd3,  8'h04, 32'hFCFF_0101, 32'hFCFF_0101},  // R3
        {4'd3,  8'h04, 32'h0000_0001, 32'h0000_0001},  // R3
        {4'd2,  8'h08, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R2
        {4'd3,  8'h08, 32'h0000_0000, 32'h0000_0000},  // R3
        {4'd2,  8'h0C, 32'hFFFF_1234, 32'h0000_1234},  // R2
        {4'd3,  8'h0C, 32'h0000_0000, 32'h0000_0000},  // R3
        {4'd3,  8'h10, 32'h0000_ABCD, 32'h0000_ABCD},  // R3
        {4'd3,  8'h10, 32'h0000_0000, 32'h0000_0000},  // R3
        {4'd2,  8'h14, 32'hFFFF_0000, 32'h0000_0000},  // R2
        {4'd2,  8'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R2
        {4'd2,  8'h24, 32'hFFFF_FFFF, 32'h0000_00FF},  // R2
        {4'd3,  8'h24, 32'h0000_005A, 32'h0000_005A},  // R3
        {4'd3,  8'h24, 32'h0000_0000, 32'h0000_0000},  // R3
        {4'd12, 8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},  // R12
        {4'd7,  8'h1C, 32'h0000_0100, 32'h0000_0000},  // R7
        {4'd5,  8'h1C, 32'h0000_000F, 32'h0000_000F},  // R5
        {4'd5,  8'h1C, 32'h0000_0000, 32'h0000_000F},  // R5
        {4'd7,  8'h1C, 32'h0000_0103, 32'h0000_000F},  // R7
        {4'd6,  8'h20, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R6
        {4'd6,  8'h20, 32'h0000_0000, 32'hFFFF_FFFF},  // R6
        {4'd6,  8'h28, 32'hA5A5_0000, 32'hA5A5_0000},  // R6
        {4'd6,  8'h28, 32'h0000_FFFF, 32'hA5A5_FFFF},  // R6
        {4'd6,  8'h28, 32'h0000_0000, 32'hA5A5_FFFF},  // R6
        {4'd4,  8'h04, 32'h0000_0000, 32'h0000_0000},  // R4
        {4'd4,  8'h04, 32'h0000_0001, 32'h0000_0000},  // R4
        {4'd4,  8'h04, 32'hFCFF_0101, 32'hFCFF_0100},  // R4
        {4'd12, 8'hFC, 32'h1234_5678, 32'h0000_0000}   // R12
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int ofs, logic [31:0] d);
        @(negedge clk);
        wa = AW'(ofs >> 2); wd = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic check_reg(string req, int ofs, logic [31:0] exp);
        @(negedge clk);
        wa = AW'(ofs >> 2);
        #1 check(req, rd, exp);
    endtask

    task automatic check_lines(string req, logic [GW-1:0] g, logic [15:0] exp);
        @(negedge clk);
        gpio = g;
        #1 check(req, {16'b0, lines}, {16'b0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0; wa = '0; wr = 1'b0; wd = '0; gpio = '0;
        do_reset();

        // R1: reset values of every word
        for (int ofs = 0; ofs <= 'h28; ofs += 4)
            check_reg("R1 reset value", ofs, (ofs == 4) ? 32'h7C00_0001 : 32'h0);
        check_lines("R1 lines idle", '0, 16'h0000);

        // table walk: write, then read back
        for (int i = 0; i < NVEC; i++) begin
            wr_reg(int'(VEC[i][71:64]), VEC[i][63:32]);
            check_reg($sformatf("R%0d vector %0d", VEC[i][75:72], i),
                      int'(VEC[i][71:64]), VEC[i][31:0]);
        end
        // R12: invalid writes left other words alone
        check_reg("R12 control-1 untouched", 'h04, 32'hFCFF_0100);
        check_reg("R12 key untouched", 'h24, 32'h0);

        // R1: reset clears the locks
        do_reset();
        check_reg("R1 lock bit restored", 'h04, 32'h7C00_0001);
        check_reg("R1 protect-low cleared", 'h20, 32'h0);
        check_reg("R1 control-2 cleared", 'h1C, 32'h0);

        // R9: default routing from port 0
        check_lines("R9 port0 pin0", GW'(1), 16'h0001);
        check_lines("R9 port0 pins 0 and 15", GW'(1) | (GW'(1) << 15), 16'h8001);
        // R10: unselected port has no effect
        check_lines("R10 port1 pin0 unselected", GW'(1) << 16, 16'h0000);
        check_lines("R10 port1 pin1 unselected", GW'(1) << 17, 16'h0000);

        // R9: line 1 from port 1
        wr_reg('h08, 32'h0000_0010);
        check_lines("R9 line1 port1", GW'(1) << 17, 16'h0002);
        check_lines("R10 line1 ignores port0", GW'(1) << 1, 16'h0000);

        // R9: line 0 from port 1
        wr_reg('h08, 32'h0000_0001);
        check_lines("R9 line0 port1", GW'(1) << 16, 16'h0001);
        check_lines("R10 line0 ignores port0", GW'(1), 16'h0000);

        // R8: top nibble of last select word drives line 15
        wr_reg('h14, 32'h0000_2000);
        check_lines("R8 line15 port2", GW'(1) << 47, 16'h8000);
        check_lines("R8 line15 ignores port0", GW'(1) << 15, 16'h0000);

        // R11: absent port codes give a low line
        wr_reg('h08, 32'h0); wr_reg('h14, 32'h0);
        wr_reg('h0C, 32'h0000_0003);
        check_lines("R11 code 3 absent", '1, 16'hFFEF);
        wr_reg('h0C, 32'h0000_000F);
        check_lines("R11 code 15 absent", '1, 16'hFFEF);
        wr_reg('h0C, 32'h0);

        // R10: only pin n reaches line n
        check_lines("R10 pin5 all ports",
                    (GW'(1) << 5) | (GW'(1) << 21) | (GW'(1) << 37), 16'h0020);

        // R8: third nibble of third select word drives line 10
        wr_reg('h10, 32'h0000_0200);
        check_lines("R8 line10 port2", GW'(1) << 42, 16'h0400);
        check_reg("R8 select readback", 'h10, 32'h0000_0200);

        done = 1'b1;
        summary();
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule